// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block is a serial two-wire slave that lets an external bus master read and write a bank of 256 byte-wide registers. It oversamples the clock and data lines in the system clock domain and detects start, repeated-start and stop conditions. It answers to one seven-bit device address. Five upper bits of that address are fixed, and the two lowest bits come from strap inputs. The block only ever pulls the data line low, through an open-drain enable output.

A write transaction carries a register index byte and then any number of data bytes. Each data byte goes into the indexed register, and the index then advances by one, wrapping from 0xFF to 0x00. The index survives stops and new transactions. A read can therefore follow a write through a repeated start. It can also stand alone, in which case it returns whatever register the index currently names. After sending one data byte, the slave releases the line and waits for the master to issue a stop or a new start.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The device address is {5'b10010, strap_sel[1:0]}, so strap 2'b11 gives 0x4B and strap 2'b00 gives 0x48. An address byte whose upper seven bits differ from this gets no acknowledge. The slave then keeps SDA released until the next start.
- R2: Every byte, in both directions, travels most significant bit first.
- R3: A stop condition (SDA rising while SCL is high) ends any transfer, including one cut off mid-byte, and releases SDA.
- R4: A start or repeated start (SDA falling while SCL is high) restarts address matching from any state, with no stop needed in between.
- R5: After a matched address byte, and after the register index byte of a write, the slave holds SDA low for the ninth SCL clock.
- R6: The register index is kept across transactions until reset or until a write changes it. A read that sends only the device address returns the indexed register.
- R7: On a matched read (R/W bit = 1), the slave acknowledges and then drives the eight bits of the indexed register.
- R8: In a write, each data byte after the index is stored at the index and acknowledged. The index then increments modulo 256.
- R9: A read leaves the index unchanged. After the read byte, the slave keeps SDA released whether the master acknowledges or not, so any further SCL clocks read back as 1.
- R10: Reset releases SDA, clears the index to 0, and loads register i with i XOR 0x5A.
- R11: The SDA enable changes only after an SCL falling edge, or when a start or stop is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_sel | input | 2 | Pin-strapped low bits of the device address |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench replays the write-then-repeated-start read sequence and the standalone read. A slave that reset its index at a stop would return the wrong register on the standalone read. Foreign addresses are sent under both strap settings. While a foreign byte is on the bus, a slave that compared the R/W bit or ignored the straps would drive SDA, and the per-clock model comparison catches it. Multi-byte writes across 0xFF check the index wrap and the increment. Reads are followed by an extra clocked byte, by a repeated start and by a stop mid-byte. A slave that kept driving after its data byte, or that missed a repeated start, would corrupt those later transfers.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] RESET_XOR = 8'h5A;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_HOLD
    } slv_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [6:0] dev_addr(input logic [4:0] prefix,
                                            input logic [1:0] strap);
        return {prefix, strap};
    endfunction

    function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx);
        return BYTE_W'(idx) ^ RESET_XOR;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_old, sda_now, sda_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    assign scl_now = scl_pipe[PIPE_W-2];
    assign scl_old = scl_pipe[PIPE_W-1];
    assign sda_now = sda_pipe[PIPE_W-2];
    assign sda_old = sda_pipe[PIPE_W-1];

    always_comb begin
        evt.scl_rise = scl_now & ~scl_old;
        evt.scl_fall = ~scl_now & scl_old;
        evt.sda      = sda_now;
        evt.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array
    import i2c_slv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(reg_reset_val(i));
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b10010,
    parameter int         PTR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe,
    output slv_state_e        state
);
    localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(BYTE_W - 1);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 ack_hi;
    logic                 rw;
    logic [BYTE_W-1:0]    rx_byte;
    logic                 byte_end;
    logic [6:0]           my_addr;
    logic                 no_cond;

    assign rx_byte  = {shreg[BYTE_W-2:0], evt.sda};
    assign byte_end = (bit_cnt == BIT_LAST);
    assign my_addr  = dev_addr(DEV_PREFIX, strap);
    assign no_cond  = ~evt.start & ~evt.stop;

    assign wr_en   = no_cond && (state == ST_WDAT) && evt.scl_rise && byte_end;
    assign wr_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            ack_hi  <= 1'b0;
            rw      <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            ack_hi <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            ack_hi  <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV, ST_REG, ST_WDAT: begin
                    if (evt.scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_end) begin
                            if (state == ST_DEV) begin
                                if (rx_byte[BYTE_W-1:1] == my_addr) begin
                                    rw    <= rx_byte[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end else if (state == ST_REG) begin
                                ptr   <= PTR_W'(rx_byte);
                                state <= ST_REG_ACK;
                            end else begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_WDAT_ACK;
                            end
                        end
                    end
                end
                ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: begin
                    if (evt.scl_fall) begin
                        if (!ack_hi) begin
                            sda_oe <= 1'b1;
                            ack_hi <= 1'b1;
                        end else begin
                            ack_hi  <= 1'b0;
                            bit_cnt <= '0;
                            if (state == ST_DEV_ACK && rw) begin
                                state  <= ST_RDAT;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (state == ST_DEV_ACK) ? ST_REG : ST_WDAT;
                            end
                        end
                    end
                end
                ST_RDAT: begin
                    if (evt.scl_fall) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_end) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RDAT_ACK;
                        end else begin
                            sda_oe <= ~shreg[BYTE_W-1];
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RDAT_ACK: begin
                    if (evt.scl_rise) begin
                        state <= ST_HOLD;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX  = 5'b10010,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] strap_sel,
    output logic       sda_pull_low
);
    bus_evt_t          bus_evt;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [PTR_W-1:0]  reg_ptr;
    slv_state_e        fsm_state;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (bus_evt)
    );

    i2c_slv_fsm #(
        .DEV_PREFIX(DEV_PREFIX),
        .PTR_W     (PTR_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (bus_evt),
        .strap   (strap_sel),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr     (reg_ptr),
        .sda_oe  (sda_pull_low),
        .state   (fsm_state)
    );

    i2c_reg_array #(
        .ADDR_W(PTR_W),
        .DATA_W(BYTE_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (reg_ptr),
        .wdata (wr_data),
        .raddr (reg_ptr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2c_slv_checker.sv
module i2c_slv_checker
    import i2c_slv_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input bus_evt_t         evt,
    input logic             sda_pull,
    input logic [PTR_W-1:0] ptr,
    input logic             wr_en,
    input slv_state_e       state
);

    p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> $past(evt.scl_fall || evt.start || evt.stop));

    p_stop_release_r3: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (!sda_pull && state == ST_IDLE));

    p_start_restart_r4: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_DEV && !sda_pull));

    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> $past(state == ST_REG || wr_en));

    p_hold_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !sda_pull);

    p_write_ack_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state == ST_WDAT_ACK));

endmodule

bind i2c_regbank_slave i2c_slv_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt      (bus_evt),
    .sda_pull (sda_pull_low),
    .ptr      (reg_ptr),
    .wr_en    (wr_en),
    .state    (fsm_state)
);

// File: tb/test_i2c_regbank_slave.sv
module test_i2c_regbank_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b11;
    logic       oe;
    logic       sda_line;

    assign sda_line = sda_m & ~oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_slave i_i2c_regbank_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .strap_sel    (strap),
        .sda_pull_low (oe)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    bit         silent = 1'b0;
    logic       oe_prev = 1'b0;
    logic [7:0] mdl_mem [256];
    logic [7:0] mdl_ptr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the slave drive against the bus model
    always @(negedge clk) begin
        if (!rst) begin
            if (oe !== oe_prev) begin
                n_chk++;
                if (scl_m) begin
                    n_fail++;
                    $display("FAIL R11: actual drive change with SCL high, expected SCL low");
                end
            end
            if (silent) begin
                n_chk++;
                if (oe !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R1: actual drive %b expected 0", oe);
                end
            end
        end
        oe_prev <= oe;
    end

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic write_bit(input logic b);
        sda_m = b;    waitq();
        scl_m = 1'b1; waitq();
        waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        b = sda_line;
        waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        read_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) read_bit(d[i]);
        write_bit(~mack);
    endtask

    function automatic logic [7:0] dev_byte(input logic rd);
        return {5'b10010, strap, rd};
    endfunction

    task automatic write_txn(input logic [7:0] ra, input logic [7:0] data[$], input bit stop_after);
        logic a;
        do_start();
        send_byte(dev_byte(1'b0), a);
        chk("R5 device ack", a, 1);
        send_byte(ra, a);
        chk("R5 index ack", a, 1);
        mdl_ptr = ra;
        foreach (data[k]) begin
            send_byte(data[k], a);
            chk("R8 data ack", a, 1);
            mdl_mem[mdl_ptr] = data[k];
            mdl_ptr = mdl_ptr + 8'd1;
        end
        if (stop_after) do_stop();
    endtask

    task automatic read_txn(input bit set_idx, input logic [7:0] ra, input logic mack,
                            input bit stop_after, input string req);
        logic a;
        logic [7:0] d;
        if (set_idx) begin
            do_start();
            send_byte(dev_byte(1'b0), a);
            chk("R5 device ack", a, 1);
            send_byte(ra, a);
            chk("R5 index ack", a, 1);
            mdl_ptr = ra;
        end
        do_start();
        send_byte(dev_byte(1'b1), a);
        chk("R7 read ack", a, 1);
        recv_byte(d, mack);
        chk(req, d, mdl_mem[mdl_ptr]);
        if (stop_after) do_stop();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'(i) ^ 8'h5A;
        mdl_ptr = 8'h00;

        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 drive in reset", oe, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 drive after reset", oe, 0);

        // R10/R6: standalone read after reset hits index 0
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R10 reset contents");

        // R7 example: strap 11, register 0x6D holds 0x49
        write_txn(8'h6D, '{8'h49}, 1'b1);
        read_txn(1'b1, 8'h6D, 1'b0, 1'b1, "R7 write-index then Sr read");
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R6 standalone read same register");

        // R1: foreign address gets no ack, slave stays silent
        do_start();
        send_byte({7'h4A, 1'b0}, a);
        chk("R1 foreign address nack", a, 0);
        silent = 1'b1;
        send_byte(8'h00, a);
        silent = 1'b0;
        chk("R1 silent after mismatch", a, 0);
        do_stop();
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R6 index kept after mismatch");

        // R1/R2 with strap 00
        strap = 2'b00;
        write_txn(8'h20, '{8'h01}, 1'b1);
        read_txn(1'b1, 8'h20, 1'b0, 1'b1, "R2 msb first value 01");
        do_start();
        silent = 1'b1;
        send_byte({7'h4B, 1'b1}, a);
        silent = 1'b0;
        chk("R1 old strap address nack", a, 0);
        do_stop();
        strap = 2'b11;

        // R8: multi-byte write and increment
        write_txn(8'h10, '{8'h11, 8'h22, 8'h33}, 1'b1);
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R8 index after three writes");
        read_txn(1'b1, 8'h10, 1'b0, 1'b1, "R8 first data byte");
        read_txn(1'b1, 8'h11, 1'b0, 1'b1, "R8 second data byte");
        read_txn(1'b1, 8'h12, 1'b0, 1'b1, "R8 third data byte");

        // R9: master acks, slave releases; index unchanged
        read_txn(1'b1, 8'h11, 1'b1, 1'b0, "R9 read with master ack");
        recv_byte(d, 1'b0);
        chk("R9 released after read byte", d, 8'hFF);
        do_stop();
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R9 index unchanged by read");

        // R4: repeated starts after a read byte
        read_txn(1'b1, 8'h10, 1'b0, 1'b0, "R4 read before Sr");
        write_txn(8'h10, '{8'hC3}, 1'b0);
        read_txn(1'b0, 8'h00, 1'b0, 1'b0, "R4 Sr re-read same index");
        read_txn(1'b1, 8'h6D, 1'b0, 1'b1, "R4 Sr new index read");

        // R8: wrap from 0xFF to 0x00
        write_txn(8'hFF, '{8'hA1, 8'hB2}, 1'b1);
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R8 index wrapped to 01");
        read_txn(1'b1, 8'hFF, 1'b0, 1'b1, "R8 byte at FF");
        read_txn(1'b1, 8'h00, 1'b0, 1'b1, "R8 byte wrapped to 00");

        // R3: stop cuts an address byte short
        do_start();
        write_bit(1'b1); write_bit(1'b0); write_bit(1'b0); write_bit(1'b1);
        do_stop();
        chk("R3 released after stop", oe, 0);
        read_txn(1'b0, 8'h00, 1'b0, 1'b1, "R3 bus usable after early stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule